// File: doc/BRIEF.md
# Serial ATA Device Control Shadow with Control-FIS Trigger

This block keeps the host-visible Device Control byte and a two-deep copy of the count and LBA task-file bytes for one Serial ATA channel. Every host write to the Device Control address is compared against the control byte that last went out on the link. If the soft-reset bit differs, or the soft-reset bit is clear and the interrupt-disable bit differs, the block forms a control-type Register FIS and presents it to the link layer until the link acknowledges it.

If the link sits in a low-power state when a FIS is due, the block first raises a wake request. It sends only after the wake handshake completes and the link reports ON. The host selects between current and previous (expanded 48-bit) task-file bytes with the high-order-byte select bit of the control byte. A write to any other command-block address clears that select bit.

Top module: `sata_devctl_shadow`

## Requirements
- R1: After reset the control byte reads 0x00, every task-file byte reads 0x00, and neither `fis_req_o` nor `wake_req_o` is asserted.
- R2: A write to address 7 that changes bit 2 (soft reset) of the control byte, compared with the last control byte sent, requests a control FIS.
- R3: While bit 2 stays 0, a write that changes bit 1 (interrupt disable) requests a control FIS. While bit 2 stays 1, a change of bit 1 requests none.
- R4: A write that changes only bit 7 (high-order-byte select) requests no FIS.
- R5: The FIS request carries type 0x27 on `fis_type_o`, 0 on `fis_cflag_o` and the control byte with bit 7 forced to 0 on `fis_ctl_o`. Request and payload are held unchanged until `fis_ack_i`.
- R6: Link state is encoded on `link_pm_i` as 0 = ON, 1 = PARTIAL, 2 = SLUMBER, 3 = not ready. With a FIS due in PARTIAL or SLUMBER, `wake_req_o` rises and is held until `wake_done_i`. In state 3 neither request rises. A FIS request rises only after a cycle with the link ON.
- R7: The trigger is judged against the last acknowledged control byte, not the last write. A change that is written and reverted before it is sent produces no FIS. A change written while a FIS is in flight produces a further FIS after the acknowledge.
- R8: Addresses 0 to 3 are task-file bytes. Each write moves the current byte into the previous byte. A read returns the previous byte when bit 7 of the control byte is 1, and the current byte when it is 0.
- R9: A write to any address 0 to 6 clears bit 7 of the control byte. Reads return the control byte at address 7 and 0x00 at addresses 4 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 3 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data for `host_addr_i` |
| link_pm_i | input | 2 | Link power state (0 ON, 1 PARTIAL, 2 SLUMBER, 3 not ready) |
| wake_done_i | input | 1 | Wake sequence finished |
| fis_ack_i | input | 1 | Link accepted the control FIS |
| wake_req_o | output | 1 | Wake request to the link |
| fis_req_o | output | 1 | Control FIS request |
| fis_type_o | output | 8 | FIS type byte |
| fis_cflag_o | output | 1 | Command/control flag of the FIS |
| fis_ctl_o | output | 8 | Control byte carried in the FIS |

## Verification
The bench changes the interrupt-disable bit while soft reset is held at 1, which must stay silent; a trigger that looks only at that bit would emit a spurious FIS. It writes a change and reverts it while the link is not ready, and it rewrites the byte while a FIS is waiting for its acknowledge. A design that compares against the last write rather than the last byte sent would either send the reverted change or drop the second one. Wake tests leave the link asleep for several cycles to show that no FIS escapes before ON, and high-order-byte tests confirm that bit 7 never reaches the FIS and that command-block writes drop readback to the current bytes.

// File: rtl/sata_dc_pkg.sv
package sata_dc_pkg;
  localparam int unsigned HOB_BIT  = 7;
  localparam int unsigned SRST_BIT = 2;
  localparam int unsigned NIEN_BIT = 1;
  localparam logic [7:0]  FIS_TYPE_CTL = 8'h27;

  typedef enum logic [1:0] {
    LINK_ON      = 2'd0,
    LINK_PARTIAL = 2'd1,
    LINK_SLUMBER = 2'd2,
    LINK_NRDY    = 2'd3
  } link_pm_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_SEND = 2'd2
  } ctl_st_e;
endpackage

// File: rtl/sata_dc_taskfile.sv
module sata_dc_taskfile #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned N  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hob_i,
  output logic          hit_o,
  output logic [DW-1:0] rdata_o
);
  logic [N-1:0][DW-1:0] cur_w;
  logic [N-1:0][DW-1:0] prev_w;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [DW-1:0] cur_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else if (we_i && addr_i == AW'(i)) begin
        prev_q <= cur_q;
        cur_q  <= wdata_i;
      end
    end
    assign cur_w[i]  = cur_q;
    assign prev_w[i] = prev_q;
  end

  assign hit_o = {1'b0, addr_i} < (AW+1)'(N);

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N; k++) begin
      if (addr_i == AW'(k)) rdata_o = hob_i ? prev_w[k] : cur_w[k];
    end
  end
endmodule

// File: rtl/sata_dc_ctl_fsm.sv
module sata_dc_ctl_fsm
  import sata_dc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ctl_i,
  input  logic [1:0]    link_pm_i,
  input  logic          wake_done_i,
  input  logic          fis_ack_i,
  output logic          wake_req_o,
  output logic          fis_req_o,
  output logic [DW-1:0] fis_ctl_o,
  output logic          pend_o
);
  localparam logic [DW-1:0] HOB_MASK = DW'(1) << HOB_BIT;

  ctl_st_e       st_q;
  logic [DW-1:0] sent_q, fis_ctl_q;
  logic          link_on, link_low;

  assign link_on  = link_pm_i == LINK_ON;
  assign link_low = link_pm_i == LINK_PARTIAL || link_pm_i == LINK_SLUMBER;

  // judged against the byte last accepted by the link
  assign pend_o = (ctl_i[SRST_BIT] != sent_q[SRST_BIT]) ||
                  (!ctl_i[SRST_BIT] && ctl_i[NIEN_BIT] != sent_q[NIEN_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sent_q    <= '0;
      fis_ctl_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pend_o) begin
          if (link_on) begin
            st_q      <= ST_SEND;
            fis_ctl_q <= ctl_i & ~HOB_MASK;
          end else if (link_low) begin
            st_q <= ST_WAKE;
          end
        end
        ST_WAKE: if (wake_done_i) st_q <= ST_IDLE;
        ST_SEND: if (fis_ack_i) begin
          sent_q <= fis_ctl_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_req_o = st_q == ST_WAKE;
  assign fis_req_o  = st_q == ST_SEND;
  assign fis_ctl_o  = fis_ctl_q;

  a_r5_fis_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fis_req_o && !fis_ack_i |=> fis_req_o && $stable(fis_ctl_o));
  a_r6_wake_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o && !wake_done_i |=> wake_req_o);
  a_r6_send_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fis_req_o) |-> $past(link_pm_i) == LINK_ON);
  a_r6_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_req_o && fis_req_o));
endmodule

// File: rtl/sata_devctl_shadow.sv
module sata_devctl_shadow
  import sata_dc_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned TF_REGS     = 4,
  parameter int unsigned DEVCTL_ADDR = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [1:0]    link_pm_i,
  input  logic          wake_done_i,
  input  logic          fis_ack_i,
  output logic          wake_req_o,
  output logic          fis_req_o,
  output logic [7:0]    fis_type_o,
  output logic          fis_cflag_o,
  output logic [DW-1:0] fis_ctl_o
);
  localparam logic [AW-1:0] DC_ADDR = AW'(DEVCTL_ADDR);

  logic [DW-1:0] devctl_q, tf_rdata;
  logic          dc_wr, cb_wr, tf_hit, pend;

  assign dc_wr = host_we_i && host_addr_i == DC_ADDR;
  assign cb_wr = host_we_i && host_addr_i != DC_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    devctl_q <= '0;
    else if (dc_wr) devctl_q <= host_wdata_i;
    else if (cb_wr) devctl_q[HOB_BIT] <= 1'b0;
  end

  sata_dc_taskfile #(.DW(DW), .AW(AW), .N(TF_REGS)) u_tf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .addr_i  (host_addr_i),
    .wdata_i (host_wdata_i),
    .hob_i   (devctl_q[HOB_BIT]),
    .hit_o   (tf_hit),
    .rdata_o (tf_rdata)
  );

  sata_dc_ctl_fsm #(.DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (devctl_q),
    .link_pm_i   (link_pm_i),
    .wake_done_i (wake_done_i),
    .fis_ack_i   (fis_ack_i),
    .wake_req_o  (wake_req_o),
    .fis_req_o   (fis_req_o),
    .fis_ctl_o   (fis_ctl_o),
    .pend_o      (pend)
  );

  always_comb begin
    if (host_addr_i == DC_ADDR) host_rdata_o = devctl_q;
    else if (tf_hit)            host_rdata_o = tf_rdata;
    else                        host_rdata_o = '0;
  end

  assign fis_type_o  = FIS_TYPE_CTL;
  assign fis_cflag_o = 1'b0;

  a_r4_hob_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_wr && !pend && !fis_req_o &&
    host_wdata_i[HOB_BIT-1:0] == devctl_q[HOB_BIT-1:0] |=> !pend);
  a_r9_hob_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_wr |=> !devctl_q[HOB_BIT]);
endmodule

// File: tb/sata_devctl_shadow_tb.sv
module sata_devctl_shadow_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;
  // {is_read, addr[2:0], data[7:0], expect[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 8'h11, 8'h00}, {1'b0, 3'd1, 8'h22, 8'h00},
    {1'b0, 3'd2, 8'h33, 8'h00}, {1'b0, 3'd2, 8'h44, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h22}, {1'b1, 3'd2, 8'h00, 8'h44},
    {1'b0, 3'd7, 8'h80, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h11},
    {1'b1, 3'd2, 8'h00, 8'h33}, {1'b1, 3'd7, 8'h00, 8'h80},
    {1'b1, 3'd3, 8'h00, 8'h00}, {1'b0, 3'd3, 8'h55, 8'h00},
    {1'b1, 3'd7, 8'h00, 8'h00}, {1'b1, 3'd3, 8'h00, 8'h55},
    {1'b1, 3'd1, 8'h00, 8'h22}, {1'b0, 3'd7, 8'h80, 8'h00},
    {1'b0, 3'd5, 8'h99, 8'h00}, {1'b1, 3'd7, 8'h00, 8'h00},
    {1'b1, 3'd5, 8'h00, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd4, 8'h00, 8'h00}
  };

  logic       clk = 0, rst_n = 0;
  logic       we = 0, wake_done = 0, ack = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] link = 0;
  logic [7:0] rdata, ftype, fctl;
  logic       wake_req, fis_req, cflag;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sata_devctl_shadow u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .link_pm_i(link),
    .wake_done_i(wake_done), .fis_ack_i(ack), .wake_req_o(wake_req),
    .fis_req_o(fis_req), .fis_type_o(ftype), .fis_cflag_o(cflag),
    .fis_ctl_o(fctl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, e);
  endtask

  task automatic expect_fis(input string req, input logic [7:0] e);
    @(negedge clk);
    chk(req, {fis_req, wake_req, cflag, ftype, fctl}, {1'b1, 1'b0, 1'b0, 8'h27, e});
  endtask

  task automatic do_ack;
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic expect_quiet(input string req);
    repeat (3) @(negedge clk);
    chk(req, {fis_req, wake_req}, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 requests", {fis_req, wake_req}, 2'b00);
    rd_chk("R1 devctl", 3'd7, 8'h00);
    rd_chk("R1 taskfile", 3'd2, 8'h00);

    // R8 R9 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) rd_chk("R8/R9 readback", VEC[i][18:16], VEC[i][7:0]);
      else wr(VEC[i][18:16], VEC[i][15:8]);
    end
    expect_quiet("R4 hob-only write");

    // R2 R5 soft reset set, held until ack
    wr(3'd7, 8'h04);
    expect_fis("R2 srst set", 8'h04);
    @(negedge clk); @(negedge clk);
    chk("R5 hold", {fis_req, fctl}, {1'b1, 8'h04});
    do_ack;
    chk("R5 release", fis_req, 1'b0);

    // R5 hob forced to 0 in FIS
    wr(3'd7, 8'h80);
    expect_fis("R5 hob cleared", 8'h00);
    do_ack;

    // R3 nien with srst 0
    wr(3'd7, 8'h02);
    expect_fis("R3 nien change", 8'h02);
    do_ack;
    wr(3'd7, 8'h06);
    expect_fis("R2 srst with nien", 8'h06);
    do_ack;
    wr(3'd7, 8'h04);
    expect_quiet("R3 nien under srst");
    wr(3'd7, 8'h00);
    expect_fis("R2 srst clear", 8'h00);
    do_ack;

    // R7 change reverted before send, link not ready
    link = 2'd3;
    wr(3'd7, 8'h04);
    expect_quiet("R6 not ready");
    wr(3'd7, 8'h00);
    link = 2'd0;
    expect_quiet("R7 reverted");

    // R7 change during in-flight FIS
    wr(3'd7, 8'h04);
    expect_fis("R7 first", 8'h04);
    wr(3'd7, 8'h00);
    chk("R7 payload held", {fis_req, fctl}, {1'b1, 8'h04});
    do_ack;
    expect_fis("R7 second", 8'h00);
    do_ack;

    // R6 wake from SLUMBER
    link = 2'd2;
    wr(3'd7, 8'h04);
    @(negedge clk);
    chk("R6 wake rise", {wake_req, fis_req}, 2'b10);
    @(negedge clk); @(negedge clk);
    chk("R6 wake held", {wake_req, fis_req}, 2'b10);
    link = 2'd0; wake_done = 1;
    @(negedge clk); wake_done = 0;
    chk("R6 wake drop", {wake_req, fis_req}, 2'b00);
    expect_fis("R6 send after wake", 8'h04);
    do_ack;

    // R6 wake from PARTIAL
    link = 2'd1;
    wr(3'd7, 8'h00);
    @(negedge clk);
    chk("R6 partial wake", {wake_req, fis_req}, 2'b10);
    link = 2'd0; wake_done = 1;
    @(negedge clk); wake_done = 0;
    expect_fis("R6 send after partial", 8'h00);
    do_ack;
    expect_quiet("R6 idle after send");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule